// File: doc/BRIEF.md
# Serial Overhead Byte Request Port

This block is the master end of a bit-serial link used to fetch path overhead bytes from an external device. When the framer wants a byte, it presents an 8-bit byte address with a request strobe. The block then sends that address one bit per cycle on a serial address line, framed by an address-enable pulse. Straight after that, it raises a data-enable pulse. During that pulse it samples 8 serial data bits returned by the external device and assembles them into the requested byte.

One port clock serves both directions. The enables and the serial address are launched on the falling edge of that clock. Returned data is sampled on the rising edge, so the external device gets half a cycle on each side. A whole request takes 16 port-clock cycles: 8 address cycles, then 8 data cycles with no gap. A busy output tells the framer when a new request can be accepted. The finished byte comes out with a one-cycle valid strobe and a copy of the address that produced it.

Top module: `ohb_req_port`

## Requirements
- R1: While reset is low, at the rising edge after reset is released, and until the first request, the outputs addr_en, data_en, addr_sdo, busy and byte_valid are all low.
- R2: Each accepted request produces one address-enable pulse on addr_en. The pulse is active high, lasts exactly 8 port-clock cycles, and starts on the falling edge that follows the accepting rising edge.
- R3: While addr_en is high, addr_sdo carries the 8 bits of the requested address, most significant bit first, one bit per cycle. It changes only on falling edges.
- R4: data_en rises on the same falling edge on which addr_en falls. It stays high for exactly 8 cycles. addr_en and data_en are never high together.
- R5: data_sdi is sampled on each rising edge while data_en is high. The first bit sampled becomes bit 7 of byte_data and the last becomes bit 0.
- R6: byte_valid is a one-cycle pulse. It is raised on the rising edge that samples the eighth data bit, which is 16 rising edges after the accepting edge. byte_addr then holds the address of that request, and busy falls on that same edge.
- R7: A request (req_valid high at a rising edge) is accepted only when busy is low, and busy is high from the accepting edge on. A request made while busy is high is ignored: it produces no address pulse and does not change the address being sent or echoed.
- R8: When data_sdi is held low for a whole request, the byte delivered is 8'h00.
- R9: While the port is idle after a request has completed, addr_en, data_en and addr_sdo are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; outputs to the external device launch on its falling edge, data_sdi is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe from the framer, sampled on the rising edge |
| req_addr | input | 8 | Address of the overhead byte to fetch |
| busy | output | 1 | High while a request is in progress; a new request is taken only when low |
| byte_valid | output | 1 | One-cycle strobe marking a completed byte |
| byte_data | output | 8 | Byte assembled from the serial data line |
| byte_addr | output | 8 | Address that the delivered byte was fetched for |
| addr_en | output | 1 | Address-enable pulse to the external device, 8 cycles |
| addr_sdo | output | 1 | Serial address line, most significant bit first |
| data_en | output | 1 | Data-enable pulse to the external device, 8 cycles |
| data_sdi | input | 1 | Serial data line from the external device |

## Verification
The assertions take two things for granted. First, reset is held low across at least one falling and one rising edge, so that both edge domains start cleared. Second, data_sdi is settled at each rising edge. The bench keeps to this: reset is held low for several cycles, and the external-device model changes data_sdi only one time unit after a falling edge. The model answers each address with a byte it computes from that address, and in one phase it holds the line low. Requests usually wait for busy to drop. On purpose, some are also raised in the middle of a transfer, so that the rule that requests made while busy are ignored is exercised.

// File: rtl/ohb_pkg.sv
// Shared widths and helpers for the serial overhead byte request port.
// Assumes address and data bytes are both carried bit-serially, MSB first.
package ohb_pkg;
    parameter int unsigned OHB_ADDR_W = 8;
    parameter int unsigned OHB_DATA_W = 8;

    // Width of a counter able to hold values 0 .. n-1 (at least 1 bit).
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/ohb_seq.sv
// Rising-edge sequencer: accepts a request when idle, walks a phase counter
// through the address cycles and then the data cycles, and presents the next
// values of the external enables and the serial address bit.
// Assumes the launch stage registers the *_nx outputs on the falling edge.
module ohb_seq #(
    parameter int unsigned AW = ohb_pkg::OHB_ADDR_W,
    parameter int unsigned DW = ohb_pkg::OHB_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          last,
    output logic [AW-1:0] cur_addr,
    output logic          ale_nx,
    output logic          dle_nx,
    output logic          sa_nx
);
    localparam int unsigned TOTAL = AW + DW;
    localparam int unsigned PHW   = ohb_pkg::cnt_w(TOTAL);
    localparam logic [PHW-1:0] PH_LAST  = PHW'(TOTAL - 1);
    localparam logic [PHW-1:0] PH_ADEND = PHW'(AW);

    logic [PHW-1:0] ph;
    logic [AW-1:0]  ashift;

    assign last   = busy && (ph == PH_LAST);
    assign ale_nx = busy && (ph < PH_ADEND);
    assign dle_nx = busy && (ph >= PH_ADEND);
    assign sa_nx  = ale_nx && ashift[AW-1];

    // Accept a request when idle, advance the phase, shift the address out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            ph       <= '0;
            ashift   <= '0;
            cur_addr <= '0;
        end else if (!busy) begin
            if (req_valid) begin
                busy     <= 1'b1;
                ph       <= '0;
                ashift   <= req_addr;
                cur_addr <= req_addr;
            end
        end else begin
            if (last) begin
                busy <= 1'b0;
                ph   <= '0;
            end else begin
                ph <= ph + 1'b1;
            end
            if (ale_nx) ashift <= {ashift[AW-2:0], 1'b0};
        end
    end

    // R7
    ignore_busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !last) |=> (busy && $stable(cur_addr)));
    // R7
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && cur_addr == $past(req_addr)));
    // R6
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);
endmodule

// File: rtl/ohb_launch.sv
// Falling-edge launch stage: retimes the enables and the serial address bit
// so that they change half a cycle away from the rising sampling edge.
// Assumes its inputs are settled by the falling edge (they come from
// rising-edge registers in the sequencer).
module ohb_launch #(
    parameter int unsigned AW = ohb_pkg::OHB_ADDR_W,
    parameter int unsigned DW = ohb_pkg::OHB_DATA_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ale_nx,
    input  logic dle_nx,
    input  logic sa_nx,
    output logic ale_q,
    output logic dle_q,
    output logic sa_q
);
    // Drive the external outputs on the falling edge, low in reset.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ale_q <= 1'b0;
            dle_q <= 1'b0;
            sa_q  <= 1'b0;
        end else begin
            ale_q <= ale_nx;
            dle_q <= dle_nx;
            sa_q  <= sa_nx;
        end
    end

    // Pulse-length checkers: count the rising edges each enable is seen high.
    localparam int unsigned RW = ohb_pkg::cnt_w(((AW > DW) ? AW : DW) + 2) + 1;
    logic [RW-1:0] ale_run, dle_run;

    // Run-length counters used only by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_run <= '0;
            dle_run <= '0;
        end else begin
            ale_run <= ale_q ? ale_run + 1'b1 : '0;
            dle_run <= dle_q ? dle_run + 1'b1 : '0;
        end
    end

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale_q && dle_q));
    // R2
    ale_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale_q) |-> (ale_run == RW'(AW)));
    // R2
    ale_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_q |-> (ale_run < RW'(AW)));
    // R4
    dle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dle_q) |-> (dle_run == RW'(DW)));
    // R4
    dle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale_q) |-> dle_q);
    // R3
    sa_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_q |-> !sa_q);
endmodule

// File: rtl/ohb_capture.sv
// Rising-edge capture: shifts the serial data in while the data-enable is
// high and, on the edge that samples the final bit, delivers the byte with
// its address and a one-cycle valid strobe.
// Assumes data_sdi is settled at each rising edge.
module ohb_capture #(
    parameter int unsigned AW = ohb_pkg::OHB_ADDR_W,
    parameter int unsigned DW = ohb_pkg::OHB_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dle_q,
    input  logic          sdi,
    input  logic          last,
    input  logic [AW-1:0] cur_addr,
    output logic          byte_valid,
    output logic [DW-1:0] byte_data,
    output logic [AW-1:0] byte_addr
);
    logic [DW-1:0] rx;

    // Shift in data bits MSB first and publish the byte on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx         <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            byte_addr  <= '0;
        end else begin
            if (dle_q) rx <= {rx[DW-2:0], sdi};
            byte_valid <= last;
            if (last) begin
                byte_data <= {rx[DW-2:0], sdi};
                byte_addr <= cur_addr;
            end
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
    // R6
    valid_at_dle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $fell(dle_q));
endmodule

// File: rtl/ohb_req_port.sv
// Top of the serial overhead byte request port. Connects the rising-edge
// sequencer, the falling-edge launch stage and the rising-edge capture.
// Assumes a single port clock and a synchronous active-low reset held
// across at least one edge of each polarity.
module ohb_req_port #(
    parameter int unsigned AW = ohb_pkg::OHB_ADDR_W,
    parameter int unsigned DW = ohb_pkg::OHB_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          byte_valid,
    output logic [DW-1:0] byte_data,
    output logic [AW-1:0] byte_addr,
    output logic          addr_en,
    output logic          addr_sdo,
    output logic          data_en,
    input  logic          data_sdi
);
    logic          last, ale_nx, dle_nx, sa_nx;
    logic [AW-1:0] cur_addr;

    ohb_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .last(last), .cur_addr(cur_addr),
        .ale_nx(ale_nx), .dle_nx(dle_nx), .sa_nx(sa_nx)
    );

    ohb_launch #(.AW(AW), .DW(DW)) u_launch (
        .clk(clk), .rst_n(rst_n), .ale_nx(ale_nx), .dle_nx(dle_nx),
        .sa_nx(sa_nx), .ale_q(addr_en), .dle_q(data_en), .sa_q(addr_sdo)
    );

    ohb_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .dle_q(data_en), .sdi(data_sdi),
        .last(last), .cur_addr(cur_addr), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_addr(byte_addr)
    );

    // R1
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!addr_en && !addr_sdo));
endmodule

// File: tb/sim_ohb_req_port.sv
module sim_ohb_req_port;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] req_addr = '0;
    logic busy, byte_valid, addr_en, addr_sdo, data_en;
    logic [7:0] byte_data, byte_addr;
    logic data_sdi = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int acc_cyc = 0;
    int n_valid = 0;
    int n_ale = 0;
    int ale_run = 0, dle_run = 0;
    logic prev_ale = 0, prev_dle = 0, prev_valid = 0, prev_busy = 0;
    logic [7:0] addr_seen = '0;
    logic [7:0] exp_addr = '0;
    bit quiet = 0;
    bit finished = 0;

    ohb_req_port u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_addr(byte_addr), .addr_en(addr_en), .addr_sdo(addr_sdo),
        .data_en(data_en), .data_sdi(data_sdi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Byte the external device model returns for a given address.
    function automatic logic [7:0] dev_byte(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'hC3;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // External device: drives the requested byte MSB first after each falling edge.
    initial begin
        int k;
        k = 0;
        forever begin
            @(negedge clk);
            #1;
            if (data_en && k < 8) begin
                data_sdi = quiet ? 1'b0 : dev_byte(addr_seen)[7-k];
                k++;
            end else begin
                data_sdi = 1'b0;
                k = 0;
            end
        end
    end

    // Monitor: samples outputs one time unit after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            if (addr_en) addr_seen = {addr_seen[6:0], addr_sdo};
            if (addr_en && !prev_ale) n_ale++;
            if (busy && !prev_busy) acc_cyc = cyc;
            if (!addr_en && prev_ale) begin
                check(ale_run == 8, "R2 addr_en length", ale_run, 8);
                check(data_en == 1'b1, "R4 data_en follows addr_en", data_en, 1);
                check(addr_seen == exp_addr, "R3 serial address", addr_seen, exp_addr);
            end
            if (!data_en && prev_dle)
                check(dle_run == 8, "R4 data_en length", dle_run, 8);
            check(!(addr_en && data_en), "R4 enables overlap", addr_en, 0);
            if (!addr_en)
                check(addr_sdo == 1'b0, "R9 addr_sdo low outside pulse", addr_sdo, 0);
            if (byte_valid) begin
                n_valid++;
                if (quiet)
                    check(byte_data == 8'h00, "R8 unused line reads zero", byte_data, 0);
                else
                    check(byte_data == dev_byte(exp_addr), "R5 byte data", byte_data, dev_byte(exp_addr));
                check(byte_addr == exp_addr, "R6 echoed address", byte_addr, exp_addr);
                check(cyc - acc_cyc == 16, "R6 latency", cyc - acc_cyc, 16);
                check(busy == 1'b0, "R6 busy drops with valid", busy, 0);
            end
            if (prev_valid)
                check(byte_valid == 1'b0, "R6 valid one cycle", byte_valid, 0);
        end
        ale_run = addr_en ? ale_run + 1 : 0;
        dle_run = data_en ? dle_run + 1 : 0;
        prev_ale = addr_en;
        prev_dle = data_en;
        prev_valid = byte_valid;
        prev_busy = busy;
    end

    // Issue one request and wait for its byte; optionally poke a request mid-transfer.
    task automatic run_req(input logic [7:0] a, input int poke_at, input logic [7:0] poke_addr);
        int start, ale0;
        while (busy) @(posedge clk);
        start = n_valid;
        ale0 = n_ale;
        @(posedge clk); #2;
        req_valid = 1'b1;
        req_addr = a;
        exp_addr = a;
        @(posedge clk); #1;
        check(busy == 1'b1, "R7 busy after accept", busy, 1);
        #1;
        req_valid = 1'b0;
        req_addr = $urandom;
        if (poke_at > 0) begin
            repeat (poke_at) @(posedge clk);
            #2;
            req_valid = 1'b1;
            req_addr = poke_addr;
            @(posedge clk); #2;
            req_valid = 1'b0;
        end
        while (n_valid == start) @(posedge clk);
        @(posedge clk); #1;
        check(n_ale - ale0 == 1, "R7 one address pulse per request", n_ale - ale0, 1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1;
        check(addr_en == 0 && data_en == 0 && addr_sdo == 0, "R1 link outputs in reset",
              {addr_en, data_en, addr_sdo}, 0);
        check(busy == 0 && byte_valid == 0, "R1 status in reset", {busy, byte_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(addr_en == 0 && data_en == 0 && busy == 0 && byte_valid == 0,
              "R1 after release", {addr_en, data_en, busy, byte_valid}, 0);

        // Directed corners
        run_req(8'h00, 0, 8'h00);
        run_req(8'hFF, 0, 8'h00);
        run_req(8'h80, 0, 8'h00);
        run_req(8'h01, 0, 8'h00);
        run_req(8'hA5, 0, 8'h00);
        // Requests while busy are ignored
        run_req(8'h3C, 3, 8'hC3);
        run_req(8'h5A, 12, 8'hFF);
        run_req(8'h77, 15, 8'h11);

        repeat (3) @(posedge clk);
        #1;
        check(addr_en == 0 && data_en == 0 && addr_sdo == 0, "R9 idle outputs low",
              {addr_en, data_en, addr_sdo}, 0);

        // Unused data line
        quiet = 1;
        run_req(8'h96, 0, 8'h00);
        run_req(8'hFF, 0, 8'h00);
        quiet = 0;

        // Random requests, some poking while busy
        for (int i = 0; i < 40; i++) begin
            logic [7:0] a;
            int p;
            a = 8'($urandom);
            p = (($urandom % 4) == 0) ? int'($urandom % 15) + 1 : 0;
            run_req(a, p, 8'($urandom));
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule